// File: doc/BRIEF.md
# Dual-Chain LCD Segment Driver Core

This block turns a serial stream of segment bits into forty parallel segment drive selections for a dot-matrix or static LCD. Two shift chains of twenty stages each share one shift clock. Each chain has its own serial input and its own serial output, which is taken from its last stage. Wiring the first chain's output to the second chain's input makes one forty-stage chain. Wiring the second chain's output to the first input of another instance widens the display.

A level-sensitive load input copies both chains into a forty-bit display latch. Each segment then has a selector that combines its latched bit with an alternation input. The selector returns a 2-bit code that names one of four bias rails. The analog switches outside this block turn that code into the real drive voltage.

The block runs on a fast system clock `clk`. The shift clock `sclk` is an ordinary input that is sampled on `clk`. A shift happens on the `clk` edge at which `sclk` is seen low after it was seen high the cycle before. The load path is also registered: while `load` is high, the latch follows the chains one `clk` cycle behind.

Top module: `seg_driver_core`

## Requirements
- R1: The chains shift only on the `clk` edge at which `sclk` is sampled low after it was sampled high on the previous edge. While `sclk` stays high, stays low or rises, both chains hold their contents.
- R2: On every shift, chain A takes `din_a` into its stage 1 and moves stage k into stage k+1. `dout_a` shows stage 20, so the bit that entered first appears on `dout_a` after 20 shifts.
- R3: Chain B behaves the same way with `din_b` and `dout_b`. If `din_b` is held low, chain B fills with zeros.
- R4: With `dout_a` wired externally to `din_b`, the bit that entered on `din_a` appears on `dout_b` after 40 shifts.
- R5: On each `clk` edge at which `load` is high, the latch takes the chain contents as they were before that edge. On each edge at which `load` is low, the latch keeps its value.
- R6: A segment whose latch bit is 1 outputs code 2'b11 (rail V5) when `df` is 1 and code 2'b00 (rail VDD) when `df` is 0.
- R7: A segment whose latch bit is 0 outputs code 2'b10 (rail V3) when `df` is 1 and code 2'b01 (rail V2) when `df` is 0.
- R8: An asynchronous active-low reset clears both chains and the latch. Straight after reset, both serial outputs are 0 and every segment outputs 2'b01 while `df` is 0.
- R9: Segment n, with n from 1 to 40, sits at bits [2n-1:2n-2] of `seg_lvl`. It is driven by latch bit n. Latch bits 1 to 20 come from chain A stages 1 to 20, and latch bits 21 to 40 come from chain B stages 1 to 20.
- R10: A change on `df` reaches `seg_lvl` in the same cycle, without waiting for a `clk` edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Shift clock, sampled; its falling edge shifts the chains |
| din_a | input | 1 | Serial input of chain A (bits 1 to 20) |
| din_b | input | 1 | Serial input of chain B (bits 21 to 40) |
| load | input | 1 | Level-sensitive latch transfer enable |
| df | input | 1 | Alternation (frame polarity) input |
| dout_a | output | 1 | Chain A stage 20 |
| dout_b | output | 1 | Chain B stage 20 |
| seg_lvl | output | 80 | Per-segment 2-bit rail code, segment 1 in the low bits |

## Verification
The case that is hardest to reach from the ports is the joined forty-stage chain. To get there, the bench routes `dout_a` into `din_b` and clocks in forty known bits. It then watches the first of those bits come out on `dout_b`, and one shift later it watches the second bit come out. The bench also holds `sclk` high and then low for several cycles to show that only a falling transition moves the chains. It sets up a latch that differs from the chains while `load` is low, which shows that the latch holds. The bench's reference model follows every cycle of this and compares both serial outputs and all forty codes on each clock.

// File: rtl/seg_driver_pkg.sv
package seg_driver_pkg;
  typedef enum logic [1:0] {
    LVL_VDD = 2'b00,
    LVL_V2  = 2'b01,
    LVL_V3  = 2'b10,
    LVL_V5  = 2'b11
  } lvl_e;

  function automatic lvl_e pick_level(input logic on, input logic alt);
    lvl_e r;
    case ({on, alt})
      2'b11:   r = LVL_V5;
      2'b10:   r = LVL_VDD;
      2'b01:   r = LVL_V3;
      default: r = LVL_V2;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/seg_fall_detect.sv
module seg_fall_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  output logic fire
);
  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = sclk;
    fire   = prev_q & ~sclk;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/seg_shift_chain.sv
module seg_shift_chain #(
  parameter int LEN = 20
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic           din,
  output logic [LEN-1:0] stages,
  output logic           dout
);
  logic [LEN-1:0] chain_q;
  logic [LEN-1:0] chain_d;

  always_comb begin
    chain_d = chain_q;
    if (shift_en) chain_d = {chain_q[LEN-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign stages = chain_q;
  assign dout   = chain_q[LEN-1];
endmodule

// File: rtl/seg_disp_latch.sv
module seg_disp_latch #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] data_in,
  output logic [W-1:0] data_q
);
  logic [W-1:0] lat_q;
  logic [W-1:0] lat_d;

  always_comb begin
    lat_d = lat_q;
    if (load) lat_d = data_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lat_q <= '0;
    else        lat_q <= lat_d;
  end

  assign data_q = lat_q;
endmodule

// File: rtl/seg_level_sel.sv
module seg_level_sel
  import seg_driver_pkg::*;
#(
  parameter int W = 40
) (
  input  logic           df,
  input  logic [W-1:0]   on_bits,
  output logic [2*W-1:0] codes
);
  for (genvar s = 0; s < W; s++) begin : g_seg
    lvl_e lvl;
    always_comb lvl = pick_level(on_bits[s], df);
    assign codes[2*s +: 2] = lvl;
  end
endmodule

// File: rtl/seg_driver_core.sv
module seg_driver_core
  import seg_driver_pkg::*;
#(
  parameter int CHAIN_LEN = 20
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       sclk,
  input  logic                       din_a,
  input  logic                       din_b,
  input  logic                       load,
  input  logic                       df,
  output logic                       dout_a,
  output logic                       dout_b,
  output logic [4*CHAIN_LEN-1:0]     seg_lvl
);
  localparam int NCHAIN = 2;
  localparam int NSEG   = NCHAIN * CHAIN_LEN;

  logic                  shift_fire;
  logic [NCHAIN-1:0]     chain_din;
  logic [NCHAIN-1:0]     chain_dout;
  logic [CHAIN_LEN-1:0]  chain_stages [NCHAIN];
  logic [CHAIN_LEN-1:0]  chain_a_q;
  logic [CHAIN_LEN-1:0]  chain_b_q;
  logic [NSEG-1:0]       latch_q;

  assign chain_din = {din_b, din_a};

  seg_fall_detect u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .sclk  (sclk),
    .fire  (shift_fire)
  );

  for (genvar c = 0; c < NCHAIN; c++) begin : g_chain
    seg_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_fire),
      .din      (chain_din[c]),
      .stages   (chain_stages[c]),
      .dout     (chain_dout[c])
    );
  end

  assign chain_a_q = chain_stages[0];
  assign chain_b_q = chain_stages[1];
  assign dout_a    = chain_dout[0];
  assign dout_b    = chain_dout[1];

  seg_disp_latch #(.W(NSEG)) u_latch (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .data_in ({chain_b_q, chain_a_q}),
    .data_q  (latch_q)
  );

  seg_level_sel #(.W(NSEG)) u_sel (
    .df      (df),
    .on_bits (latch_q),
    .codes   (seg_lvl)
  );
endmodule

// File: rtl/seg_driver_chk.sv
module seg_driver_chk #(
  parameter int CHAIN_LEN = 20
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sclk,
  input logic                   din_a,
  input logic                   din_b,
  input logic                   load,
  input logic                   df,
  input logic                   shift_fire,
  input logic [CHAIN_LEN-1:0]   chain_a_q,
  input logic [CHAIN_LEN-1:0]   chain_b_q,
  input logic [2*CHAIN_LEN-1:0] latch_q,
  input logic [4*CHAIN_LEN-1:0] seg_lvl
);
  // R1
  fire_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |-> !sclk);
  // R1
  no_shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_fire |=> ($stable(chain_a_q) && $stable(chain_b_q)));
  // R2
  entry_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> chain_a_q[0] == $past(din_a));
  // R3
  entry_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_fire |=> chain_b_q[0] == $past(din_b));
  // R5
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(latch_q));
  // R5
  latch_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> latch_q == $past({chain_b_q, chain_a_q}));
  // R6
  sel_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    latch_q[0] |-> (seg_lvl[1:0] == 2'b11 || seg_lvl[1:0] == 2'b00));
  // R7
  sel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !latch_q[0] |-> (seg_lvl[1:0] == 2'b10 || seg_lvl[1:0] == 2'b01));
  // R10
  df_top_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_lvl[4*CHAIN_LEN-1] == df);
endmodule

bind seg_driver_core seg_driver_chk #(.CHAIN_LEN(CHAIN_LEN)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sclk       (sclk),
  .din_a      (din_a),
  .din_b      (din_b),
  .load       (load),
  .df         (df),
  .shift_fire (shift_fire),
  .chain_a_q  (chain_a_q),
  .chain_b_q  (chain_b_q),
  .latch_q    (latch_q),
  .seg_lvl    (seg_lvl)
);

// File: tb/seg_driver_core_tb.sv
module seg_driver_core_tb;
  localparam int L = 20;
  localparam int N = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, tb_din_a = 1'b0, tb_din_b = 1'b0, load = 1'b0, df = 1'b0;
  logic join_m = 1'b0;
  logic dout_a, dout_b;
  logic [2*N-1:0] seg_lvl;
  logic din_b_w;
  int checks = 0, fails = 0;
  bit done = 0;

  assign din_b_w = join_m ? dout_a : tb_din_b;

  always #5 clk = ~clk;

  seg_driver_core #(.CHAIN_LEN(L)) u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din_a(tb_din_a), .din_b(din_b_w),
    .load(load), .df(df), .dout_a(dout_a), .dout_b(dout_b), .seg_lvl(seg_lvl)
  );

  // behavioural reference: index 1 = stage 1
  bit ma [1:L];
  bit mb [1:L];
  bit ml [1:N];
  bit psclk;
  bit fire_m, inb_m;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 1; i <= L; i++) begin ma[i] = 0; mb[i] = 0; end
      for (int i = 1; i <= N; i++) ml[i] = 0;
      psclk = 0;
    end else begin
      fire_m = psclk && !sclk;
      inb_m  = join_m ? ma[L] : tb_din_b;
      if (load) for (int i = 1; i <= L; i++) begin ml[i] = ma[i]; ml[L+i] = mb[i]; end
      if (fire_m) begin
        for (int i = L; i > 1; i--) begin ma[i] = ma[i-1]; mb[i] = mb[i-1]; end
        ma[1] = tb_din_a;
        mb[1] = inb_m;
      end
      psclk = sclk;
    end
  end

  function automatic logic [1:0] code_of(bit on, logic alt);
    if (on) return alt ? 2'b11 : 2'b00;
    return alt ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [2*N-1:0] exp_seg();
    logic [2*N-1:0] r;
    for (int n = 1; n <= N; n++) r[2*n-2 +: 2] = code_of(ml[n], df);
    return r;
  endfunction

  task automatic check(string req, logic [2*N-1:0] act, logic [2*N-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2 dout_a", {79'd0, dout_a}, {79'd0, ma[L]});
      check("R3 dout_b", {79'd0, dout_b}, {79'd0, mb[L]});
      check("R9 seg_lvl", seg_lvl, exp_seg());
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic shift_one(bit a, bit b);
    sclk = 1'b1; tb_din_a = a; tb_din_b = b; tick();
    sclk = 1'b0; tick();
  endtask

  function automatic logic [2*N-1:0] all_code(logic [1:0] c);
    logic [2*N-1:0] r;
    for (int n = 0; n < N; n++) r[2*n +: 2] = c;
    return r;
  endfunction

  bit pat [0:L-1];
  bit jp  [0:N-1];
  logic keep_a;

  initial begin
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    @(negedge clk);
    // R8 reset state
    check("R8 seg after reset", seg_lvl, all_code(2'b01));
    check("R8 douts after reset", {78'd0, dout_a, dout_b}, '0);
    tick();
    df = 1'b1; #1;
    // R7 and R10: latched zeros with df high, no clock edge in between
    check("R7 R10 zeros df=1", seg_lvl, all_code(2'b10));
    tick();

    for (int i = 0; i < L; i++) pat[i] = (i % 3 != 1);
    for (int i = 0; i < L; i++) shift_one(pat[i], 1'b0);
    @(negedge clk);
    // R2: first-entered bit on dout_a after 20 shifts
    check("R2 dout_a first bit", {79'd0, dout_a}, {79'd0, pat[0]});
    // R3: din_b held low leaves chain B empty
    check("R3 dout_b zero fill", {79'd0, dout_b}, '0);
    // R5: load low, latch unchanged
    check("R5 hold while load low", seg_lvl, all_code(2'b10));

    tick();
    load = 1'b1; tick(); load = 1'b0;
    @(negedge clk);
    // R9 and R6: O20 holds the first bit (1), df=1 -> 11
    check("R9 R6 O20 code", {78'd0, seg_lvl[2*L-1 -: 2]}, {78'd0, 2'b11});
    // R9: O1 holds the last bit
    check("R9 O1 code", {78'd0, seg_lvl[1:0]}, {78'd0, code_of(pat[L-1], 1'b1)});
    // R7: O21 from chain B stage 1 is 0
    check("R7 O21 code", {78'd0, seg_lvl[2*L +: 2]}, {78'd0, 2'b10});
    tick();
    df = 1'b0; #1;
    // R6 and R10: selected segment moves to 00 at once
    check("R6 R10 O20 df=0", {78'd0, seg_lvl[2*L-1 -: 2]}, {78'd0, 2'b00});
    tick();

    // R1: sclk held high, then held low, then rising: no movement
    keep_a = dout_a;
    sclk = 1'b1; tb_din_a = ~keep_a; repeat (5) tick();
    @(negedge clk);
    check("R1 no shift while sclk high", {79'd0, dout_a}, {79'd0, keep_a});
    tick();
    sclk = 1'b0; tick(); // one real falling edge
    keep_a = dout_a;
    repeat (5) tick();
    sclk = 1'b1; tick();
    @(negedge clk);
    check("R1 no shift on low or rise", {79'd0, dout_a}, {79'd0, keep_a});
    tick();
    sclk = 1'b0; tick();

    // R3: chain B with its own data
    for (int i = 0; i < L; i++) shift_one(1'b0, (i % 2 == 0));
    @(negedge clk);
    check("R3 dout_b first bit", {79'd0, dout_b}, {79'd1});
    tick();

    // R4: join the chains into 40 stages
    join_m = 1'b1;
    for (int i = 0; i < N; i++) jp[i] = (i % 4 == 0) || (i == 7);
    for (int i = 0; i < N; i++) shift_one(jp[i], 1'b0);
    @(negedge clk);
    check("R4 joined 40 delay", {79'd0, dout_b}, {79'd0, jp[0]});
    tick();
    shift_one(1'b0, 1'b0);
    @(negedge clk);
    check("R4 joined next bit", {79'd0, dout_b}, {79'd0, jp[1]});
    tick();
    load = 1'b1; df = 1'b1; repeat (3) tick(); load = 1'b0;
    @(negedge clk);
    // R5: while load high the latch follows the chains
    check("R5 load follows chains", seg_lvl, exp_seg());
    tick();
    join_m = 1'b0;

    // R8: reset mid-run clears everything
    rst_n = 1'b0; df = 1'b0; tick(); rst_n = 1'b1; tick();
    @(negedge clk);
    check("R8 seg after second reset", seg_lvl, all_code(2'b01));
    check("R8 douts after second reset", {78'd0, dout_a, dout_b}, '0);
    tick();

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule